// File: doc/BRIEF.md
# Analog-shared GPIO port controller

This block controls a 16-pin general-purpose port whose pads are also wired to analog converter inputs. Three 16-bit registers, for output data, pin direction and digital input enable, sit behind a small byte-wide register bus. Each register is reached as an upper byte (bits 15..8) and a lower byte (bits 7..0). For every pin the block drives an output value and an output enable toward a tri-state pad.

Reading the data register does not simply return what was written. A pin configured as an output reads back its stored bit. An input pin with its digital buffer on reads back its pad level, taken through a two-flop synchroniser. An input pin with its digital buffer off reads back a constant 1. While the buffer is off, the synchroniser input is held at 1, so an analog voltage on the pad never toggles any logic. After reset every pin is an undriven analog input.

Top module: `ana_gpio_port`

## Requirements
- R1: After reset the data, direction and input-enable registers are all zero, so pad_out_o and pad_oe_o are zero and both data bytes read 8'hFF.
- R2: Offset 2 holds direction bits 15..8 and offset 3 holds direction bits 7..0. Offset 4 holds input-enable bits 15..8 and offset 5 holds input-enable bits 7..0. Each of these bytes reads back exactly what was last written to it.
- R3: pad_oe_o bit n equals direction bit n.
- R4: pad_out_o bit n equals stored data bit n, including bits written while the pin was an input. pad_out_o and pad_oe_o change only in the cycle after a write strobe.
- R5: When direction bit n is 1, data bit n reads back as the stored bit, whatever the pad level.
- R6: When direction bit n is 0 and input-enable bit n is 0, data bit n reads back as 1.
- R7: When direction bit n is 0 and input-enable bit n is 1, data bit n reads back the pad level. A pad change shows up after the second rising clock edge and not after the first.
- R8: Offset 0 reads and writes data bits 15..8 and offset 1 reads and writes data bits 7..0. Offsets 6 and 7 read 0, and writes to them change no register.
- R9: No register changes unless we_i is high at the clock edge. The read data on rdata_o is combinational from addr_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Byte offset of the register access |
| we_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | 8 | Write data byte |
| rdata_o | output | 8 | Combinational read data byte |
| pad_in_i | input | 16 | Pad input levels |
| pad_out_o | output | 16 | Pad output values |
| pad_oe_o | output | 16 | Pad output enables |

## Verification
The bench builds the block with its default of 16 pins. That gives two bytes per register and a 3-bit offset, so the two unmapped offsets 6 and 7 can be reached alongside both byte lanes of every register. Random writes mix the direction and input-enable settings of individual pins within one byte. This covers all three read-back cases and changes of input enable while the pad is held. A directed sequence samples the read-back after one and after two clock edges to pin down the synchroniser depth.

// File: rtl/ana_gpio_pkg.sv
package ana_gpio_pkg;
  localparam int BYTE_W  = 8;
  localparam int NUM_REG = 3;
  typedef enum int {REG_DAT = 0, REG_DIR = 1, REG_IEN = 2} reg_sel_e;
endpackage

// File: rtl/ana_gpio_regs.sv
module ana_gpio_regs
  import ana_gpio_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int ADDR_W   = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                we_i,
  input  logic [BYTE_W-1:0]   wdata_i,
  output logic [NUM_PINS-1:0] dat_o,
  output logic [NUM_PINS-1:0] dir_o,
  output logic [NUM_PINS-1:0] ien_o
);
  localparam int BYTES = NUM_PINS / BYTE_W;

  logic [NUM_REG*NUM_PINS-1:0] flat;

  // offset = reg*BYTES + b, b=0 is the most significant byte
  for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
    for (genvar b = 0; b < BYTES; b++) begin : g_byte
      localparam int OFF  = r * BYTES + b;
      localparam int LANE = BYTES - 1 - b;
      logic [BYTE_W-1:0] byte_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) byte_q <= '0;
        else if (we_i && (int'(addr_i) == OFF)) byte_q <= wdata_i;
      end
      assign flat[r*NUM_PINS + LANE*BYTE_W +: BYTE_W] = byte_q;
    end
  end

  assign dat_o = flat[REG_DAT*NUM_PINS +: NUM_PINS];
  assign dir_o = flat[REG_DIR*NUM_PINS +: NUM_PINS];
  assign ien_o = flat[REG_IEN*NUM_PINS +: NUM_PINS];
endmodule

// File: rtl/ana_gpio_sync.sv
module ana_gpio_sync #(
  parameter int NUM_PINS = 16,
  parameter int STAGES   = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pad_i,
  input  logic [NUM_PINS-1:0] ien_i,
  output logic [NUM_PINS-1:0] sync_o
);
  logic [NUM_PINS-1:0] stage_q [STAGES];
  logic [NUM_PINS-1:0] gated;

  // disabled buffer: feed constant 1 so analog levels never toggle logic
  assign gated = (pad_i & ien_i) | ~ien_i;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '1;
      else if (s == 0) stage_q[s] <= gated;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/ana_gpio_rdmux.sv
module ana_gpio_rdmux
  import ana_gpio_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int ADDR_W   = 3
) (
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [NUM_PINS-1:0] dat_i,
  input  logic [NUM_PINS-1:0] dir_i,
  input  logic [NUM_PINS-1:0] ien_i,
  input  logic [NUM_PINS-1:0] sync_i,
  output logic [BYTE_W-1:0]   rdata_o
);
  localparam int BYTES = NUM_PINS / BYTE_W;

  logic [NUM_PINS-1:0] pin_rd;
  logic [NUM_PINS-1:0] view [NUM_REG];

  assign pin_rd = (dir_i & dat_i) | (~dir_i & ien_i & sync_i) | (~dir_i & ~ien_i);

  assign view[REG_DAT] = pin_rd;
  assign view[REG_DIR] = dir_i;
  assign view[REG_IEN] = ien_i;

  always_comb begin
    rdata_o = '0;
    for (int r = 0; r < NUM_REG; r++) begin
      for (int b = 0; b < BYTES; b++) begin
        if (int'(addr_i) == r * BYTES + b)
          rdata_o = view[r][(BYTES-1-b)*BYTE_W +: BYTE_W];
      end
    end
  end
endmodule

// File: rtl/ana_gpio_port.sv
module ana_gpio_port
  import ana_gpio_pkg::*;
#(
  parameter int NUM_PINS  = 16,
  parameter int SYNC_LEN  = 2,
  localparam int BYTES    = NUM_PINS / BYTE_W,
  localparam int ADDR_W   = $clog2(NUM_REG * BYTES)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                we_i,
  input  logic [BYTE_W-1:0]   wdata_i,
  output logic [BYTE_W-1:0]   rdata_o,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o
);
  logic [NUM_PINS-1:0] dat_q, dir_q, ien_q, sync_q;

  ana_gpio_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
    .wdata_i(wdata_i), .dat_o(dat_q), .dir_o(dir_q), .ien_o(ien_q)
  );

  ana_gpio_sync #(.NUM_PINS(NUM_PINS), .STAGES(SYNC_LEN)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .pad_i(pad_in_i), .ien_i(ien_q),
    .sync_o(sync_q)
  );

  ana_gpio_rdmux #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_rdmux (
    .addr_i(addr_i), .dat_i(dat_q), .dir_i(dir_q), .ien_i(ien_q),
    .sync_i(sync_q), .rdata_o(rdata_o)
  );

  assign pad_out_o = dat_q;
  assign pad_oe_o  = dir_q;
endmodule

// File: rtl/ana_gpio_port_chk.sv
module ana_gpio_port_chk #(
  parameter int NUM_PINS = 16,
  parameter int ADDR_W   = 3
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [ADDR_W-1:0]   addr_i,
  input logic                we_i,
  input logic [7:0]          rdata_i,
  input logic [NUM_PINS-1:0] pad_out_i,
  input logic [NUM_PINS-1:0] pad_oe_i,
  input logic [NUM_PINS-1:0] ien_i
);
  localparam int BYTES  = NUM_PINS / 8;
  localparam int LO_OFF = BYTES - 1;
  localparam int HOLE   = 3 * BYTES;

  always @(posedge clk_i) begin
    if (!rst_ni) assert_reset_idle_R1: assert (pad_oe_i == '0 && pad_out_i == '0);
  end

  assert_oe_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(pad_oe_i));

  assert_out_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(pad_out_i));

  assert_rd_output_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(addr_i) == LO_OFF && (&pad_oe_i[7:0])) |-> rdata_i == pad_out_i[7:0]);

  assert_rd_analog_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(addr_i) == LO_OFF && pad_oe_i[7:0] == 8'h00 && ien_i[7:0] == 8'h00)
      |-> rdata_i == 8'hFF);

  assert_rd_hole_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(addr_i) >= HOLE) |-> rdata_i == 8'h00);
endmodule

bind ana_gpio_port ana_gpio_port_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
  .rdata_i(rdata_o), .pad_out_i(pad_out_o), .pad_oe_i(pad_oe_o), .ien_i(ien_q)
);

// File: tb/sim_ana_gpio_port.sv
module sim_ana_gpio_port;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 16;

  logic        clk = 0, rst_n = 0, we = 0;
  logic [2:0]  addr = '0;
  logic [7:0]  wdata = '0, rdata;
  logic [NP-1:0] pad_in = '0, pad_out, pad_oe;
  logic [NP-1:0] m_dat = '0, m_dir = '0, m_ien = '0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ana_gpio_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe)
  );

  function automatic logic [7:0] exp_rd(int off, logic [NP-1:0] pad);
    logic [NP-1:0] rb, v;
    if (off >= 6) return 8'h00;
    rb = (m_dir & m_dat) | (~m_dir & m_ien & pad) | (~m_dir & ~m_ien);
    v = (off / 2 == 0) ? rb : (off / 2 == 1) ? m_dir : m_ien;
    return v[(1 - off % 2) * 8 +: 8];
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int off, logic [7:0] d);
    @(negedge clk);
    addr = 3'(off); wdata = d; we = 1;
    @(posedge clk);
    if (off < 6) begin
      case (off / 2)
        0: m_dat[(1 - off % 2) * 8 +: 8] = d;
        1: m_dir[(1 - off % 2) * 8 +: 8] = d;
        default: m_ien[(1 - off % 2) * 8 +: 8] = d;
      endcase
    end
    @(negedge clk);
    we = 0;
  endtask

  task automatic settle();
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd_all(string req);
    for (int o = 0; o < 8; o++) begin
      addr = 3'(o); #1;
      chk(req, {8'h00, rdata}, {8'h00, exp_rd(o, pad_in)});
    end
    chk("R3", pad_oe, m_dir);
    chk("R4", pad_out, m_dat);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    addr = 3'd0; #1; chk("R1", {8'h00, rdata}, 16'h00FF);
    addr = 3'd1; #1; chk("R1", {8'h00, rdata}, 16'h00FF);
    chk("R1", pad_oe, 16'h0000);
    chk("R1", pad_out, 16'h0000);
    rst_n = 1;
    @(negedge clk);

    // R2 direction/enable byte lanes
    wr(2, 8'hA5); wr(3, 8'h3C); wr(4, 8'h0F); wr(5, 8'hF0);
    addr = 3'd2; #1; chk("R2", {8'h00, rdata}, 16'h00A5);
    addr = 3'd5; #1; chk("R2", {8'h00, rdata}, 16'h00F0);
    chk("R3", pad_oe, 16'hA53C);

    // R4 write while input, then turn to output
    wr(2, 8'h00); wr(3, 8'h00);
    wr(0, 8'h5A); wr(1, 8'hC3);
    chk("R4", pad_oe, 16'h0000);
    chk("R4", pad_out, 16'h5AC3);
    wr(3, 8'hFF);
    chk("R4", pad_oe, 16'h00FF);

    // R5 output readback ignores pad
    pad_in = 16'h003C; settle();
    addr = 3'd1; #1; chk("R5", {8'h00, rdata}, 16'h00C3);

    // R6 input with buffer off reads 1 despite pad
    wr(3, 8'h00); wr(5, 8'h00); pad_in = 16'h0000; settle();
    addr = 3'd1; #1; chk("R6", {8'h00, rdata}, 16'h00FF);

    // R7 synchroniser depth
    wr(5, 8'hFF); settle();
    addr = 3'd1; #1; chk("R7", {8'h00, rdata}, 16'h0000);
    pad_in = 16'h0081;
    @(posedge clk); @(negedge clk);
    chk("R7", {8'h00, rdata}, 16'h0000);
    @(posedge clk); @(negedge clk);
    chk("R7", {8'h00, rdata}, 16'h0081);

    // R8 holes ignore writes
    wr(6, 8'hFF); wr(7, 8'hFF);
    rd_all("R8");

    // R9 no write without strobe
    @(negedge clk); addr = 3'd0; wdata = 8'hEE; we = 0;
    repeat (2) @(posedge clk); @(negedge clk);
    rd_all("R9");

    // random mix
    for (int i = 0; i < 300; i++) begin
      wr(int'($urandom_range(0, 7)), 8'($urandom));
      if ($urandom_range(0, 3) == 0) pad_in = 16'($urandom);
      settle();
      rd_all((i % 2 == 0) ? "R7" : "R2");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule